// File: doc/BRIEF.md
# In-Order Completion Queue Controller

This block tracks instructions in program order from the moment they are dispatched until they retire. Each cycle an instruction queue asks to dispatch zero, one or two instructions. The controller grants as many as it has room for, gives each granted instruction a queue slot, and records which execution unit that instruction was sent to. Execution units later report that a slot has finished by giving its index on a finish port. Finished instructions keep their slot until every older instruction has retired.

Up to two of the oldest finished slots retire each cycle, and the unit code of each retiring instruction is reported. The queue is a six-entry circular buffer. Its head and tail pointers each carry a wrap bit, so a full queue and an empty queue can be told apart. When the grant is smaller than the request, a hold signal tells the instruction queue to keep the instructions that were not granted. A slot that retires becomes free for dispatch on the next cycle. An optional bypass parameter lets dispatch reuse a slot in the same cycle that it retires.

Top module: `cq_ctrl`

## Requirements
- R1: A synchronous active-high reset empties the queue and clears every finished flag. The first cycle after reset reports no retirement, and a request for two instructions is granted in full at slots 0 and 1.
- R2: The grant is the smallest of three values: the request, the number 2, and the number of free slots. Granted instructions take consecutive slots starting at the tail. The first granted instruction gets `disp_idx0`, and the second gets `disp_idx1`.
- R3: `iq_hold` is high exactly when the grant is smaller than the request. A full queue grants nothing.
- R4: A finish mark on an occupied slot sets that slot's finished flag at the clock edge. The slot can retire in the cycle after the mark, and no earlier.
- R5: Retirement is strictly in program order. A finished slot waits while any older slot in the queue is still unfinished.
- R6: At most two slots retire per cycle. `ret_vld[1]` may be high only when `ret_vld[0]` is high, and bit 0 always reports the oldest slot.
- R7: With the default setting of no bypass, slots freed by retirement cannot be granted until the next cycle. A full queue that is retiring still grants 0 in that cycle.
- R8: A finish mark whose index names an empty slot, or an index of 6 or more, raises `fin_err` in the same cycle and changes no slot.
- R9: Unit codes are INT=0, FP=1, LSU=2, BR=3. The code given at dispatch is the code reported with that instruction at retirement.
- R10: Slot indices wrap from 5 back to 0. The wrap bit keeps a full queue distinct from an empty one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| disp_req | input | 2 | Number of instructions requested for dispatch (0 to 2) |
| disp_unit0 | input | 2 | Unit code of the first requested instruction |
| disp_unit1 | input | 2 | Unit code of the second requested instruction |
| disp_grant | output | 2 | Number of instructions granted this cycle |
| disp_idx0 | output | 3 | Slot given to the first granted instruction |
| disp_idx1 | output | 3 | Slot given to the second granted instruction |
| iq_hold | output | 1 | Tells the instruction queue to keep the instructions that were not granted |
| fin_vld | input | 2 | Valid bit of each finish port |
| fin_idx | input | 2x3 | Slot index carried by each finish port |
| fin_err | output | 1 | A valid finish mark named an empty or out-of-range slot |
| ret_vld | output | 2 | Retire valid for the two retire lanes; lane 0 is the oldest |
| ret_unit0 | output | 2 | Unit code of the instruction retiring on lane 0 |
| ret_unit1 | output | 2 | Unit code of the instruction retiring on lane 1 |

## Verification
The checker keeps its own occupancy count, built only from grants and retirements, and tests several properties on every cycle. It checks that a grant never goes beyond the free slots and that the occupancy never goes above six. It checks that a hold only happens when there is not enough room, and that lane 1 never retires without lane 0. It also checks that an empty queue never retires, that a full queue without bypass grants nothing, and that the two dispatch indices are consecutive modulo six. Some behaviours need the bench's scenarios to show them, because they depend on which instruction sits in which slot. These are strict ordering when a younger slot finishes first, the one-cycle delay from a finish mark to retirement, unit codes carried through to retirement, finish marks on empty slots having no effect, and reset clearing finished flags.

// File: rtl/cq_pkg.sv
package cq_pkg;

    localparam int LANES = 2;

    typedef enum logic [1:0] {
        UNIT_INT = 2'd0,
        UNIT_FP  = 2'd1,
        UNIT_LSU = 2'd2,
        UNIT_BR  = 2'd3
    } unit_e;

    typedef struct packed {
        logic  busy;
        logic  done;
        unit_e unit;
    } cq_entry_t;

    function automatic int lesser(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/cq_ptr.sv
module cq_ptr #(
    parameter  int DEPTH = 6,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [1:0]      push_n,
    input  logic [1:0]      pop_n,
    output logic [IDXW-1:0] head_i,
    output logic [IDXW-1:0] head_i1,
    output logic [IDXW-1:0] tail_i,
    output logic [IDXW-1:0] tail_i1,
    output logic [CNTW-1:0] occ
);

    logic            h_w, t_w;
    logic [IDXW-1:0] h_i, t_i;

    function automatic logic [IDXW:0] step(input logic w, input logic [IDXW-1:0] i,
                                           input logic [1:0] n);
        int s;
        s = int'(i) + int'(n);
        if (s >= DEPTH) return {~w, IDXW'(s - DEPTH)};
        return {w, IDXW'(s)};
    endfunction

    logic [IDXW:0] h_next, t_next, h_plus1, t_plus1;

    always_comb begin
        h_next  = step(h_w, h_i, pop_n);
        t_next  = step(t_w, t_i, push_n);
        h_plus1 = step(h_w, h_i, 2'd1);
        t_plus1 = step(t_w, t_i, 2'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_w <= 1'b0;
            h_i <= '0;
            t_w <= 1'b0;
            t_i <= '0;
        end else begin
            {h_w, h_i} <= h_next;
            {t_w, t_i} <= t_next;
        end
    end

    always_comb begin
        if (h_w == t_w) occ = CNTW'(int'(t_i) - int'(h_i));
        else            occ = CNTW'(DEPTH - int'(h_i) + int'(t_i));
    end

    assign head_i  = h_i;
    assign tail_i  = t_i;
    assign head_i1 = h_plus1[IDXW-1:0];
    assign tail_i1 = t_plus1[IDXW-1:0];

endmodule

// File: rtl/cq_grant.sv
module cq_grant #(
    parameter  int DEPTH  = 6,
    parameter  bit BYPASS = 1'b0,
    localparam int CNTW   = $clog2(DEPTH + 1)
) (
    input  logic [1:0]      req,
    input  logic [CNTW-1:0] occ,
    input  logic [1:0]      ret_n,
    output logic [1:0]      grant,
    output logic            hold
);
    import cq_pkg::*;

    always_comb begin
        int free_n;
        int want;
        int g;
        free_n = DEPTH - int'(occ) + (BYPASS ? int'(ret_n) : 0);
        want   = lesser(int'(req), LANES);
        g      = lesser(want, free_n);
        grant  = 2'(g);
        hold   = int'(req) > g;
    end

endmodule

// File: rtl/cq_entries.sv
module cq_entries #(
    parameter  int DEPTH = 6,
    parameter  int NFIN  = 2,
    localparam int IDXW  = $clog2(DEPTH),
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [IDXW-1:0]           head_i,
    input  logic [IDXW-1:0]           head_i1,
    input  logic [IDXW-1:0]           tail_i,
    input  logic [IDXW-1:0]           tail_i1,
    input  logic [CNTW-1:0]           occ,
    input  logic [1:0]                grant,
    input  cq_pkg::unit_e             unit0,
    input  cq_pkg::unit_e             unit1,
    input  logic [NFIN-1:0]           fin_vld,
    input  logic [NFIN-1:0][IDXW-1:0] fin_idx,
    output logic [1:0]                ret_vld,
    output cq_pkg::unit_e             ret_u0,
    output cq_pkg::unit_e             ret_u1,
    output logic                      fin_err
);
    import cq_pkg::*;

    cq_entry_t       q [DEPTH];
    logic [DEPTH-1:0] mark;
    logic [NFIN-1:0]  bad;

    // Finish decode: a mark lands only on an occupied slot.
    always_comb begin
        mark = '0;
        bad  = fin_vld;
        for (int p = 0; p < NFIN; p++) begin
            for (int e = 0; e < DEPTH; e++) begin
                if (fin_vld[p] && fin_idx[p] == IDXW'(e) && q[e].busy) begin
                    mark[e] = 1'b1;
                    bad[p]  = 1'b0;
                end
            end
        end
    end

    assign fin_err = |bad;

    // In-order two-lane retirement from the head.
    always_comb begin
        ret_vld[0] = (occ != '0) && q[head_i].done;
        ret_vld[1] = ret_vld[0] && (occ >= CNTW'(2)) && q[head_i1].done;
        ret_u0     = q[head_i].unit;
        ret_u1     = q[head_i1].unit;
    end

    always_ff @(posedge clk) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (rst) begin
                q[e] <= '0;
            end else begin
                if (mark[e]) q[e].done <= 1'b1;
                if ((ret_vld[0] && head_i == IDXW'(e)) ||
                    (ret_vld[1] && head_i1 == IDXW'(e)))
                    q[e] <= '0;
                if (grant != 2'd0 && tail_i == IDXW'(e))
                    q[e] <= '{busy: 1'b1, done: 1'b0, unit: unit0};
                else if (grant == 2'd2 && tail_i1 == IDXW'(e))
                    q[e] <= '{busy: 1'b1, done: 1'b0, unit: unit1};
            end
        end
    end

endmodule

// File: rtl/cq_ctrl.sv
module cq_ctrl #(
    parameter  int DEPTH  = 6,
    parameter  bit BYPASS = 1'b0,
    parameter  int NFIN   = 2,
    localparam int IDXW   = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [1:0]                disp_req,
    input  logic [1:0]                disp_unit0,
    input  logic [1:0]                disp_unit1,
    output logic [1:0]                disp_grant,
    output logic [IDXW-1:0]           disp_idx0,
    output logic [IDXW-1:0]           disp_idx1,
    output logic                      iq_hold,
    input  logic [NFIN-1:0]           fin_vld,
    input  logic [NFIN-1:0][IDXW-1:0] fin_idx,
    output logic                      fin_err,
    output logic [1:0]                ret_vld,
    output logic [1:0]                ret_unit0,
    output logic [1:0]                ret_unit1
);
    import cq_pkg::*;

    localparam int CNTW = $clog2(DEPTH + 1);

    logic [IDXW-1:0] head_i, head_i1, tail_i, tail_i1;
    logic [CNTW-1:0] occ;
    logic [1:0]      ret_n;
    unit_e           ru0, ru1;

    assign ret_n = 2'(ret_vld[0]) + 2'(ret_vld[1]);

    cq_ptr #(.DEPTH(DEPTH)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .push_n (disp_grant),
        .pop_n  (ret_n),
        .head_i (head_i),
        .head_i1(head_i1),
        .tail_i (tail_i),
        .tail_i1(tail_i1),
        .occ    (occ)
    );

    cq_grant #(.DEPTH(DEPTH), .BYPASS(BYPASS)) u_grant (
        .req  (disp_req),
        .occ  (occ),
        .ret_n(ret_n),
        .grant(disp_grant),
        .hold (iq_hold)
    );

    cq_entries #(.DEPTH(DEPTH), .NFIN(NFIN)) u_ent (
        .clk    (clk),
        .rst    (rst),
        .head_i (head_i),
        .head_i1(head_i1),
        .tail_i (tail_i),
        .tail_i1(tail_i1),
        .occ    (occ),
        .grant  (disp_grant),
        .unit0  (unit_e'(disp_unit0)),
        .unit1  (unit_e'(disp_unit1)),
        .fin_vld(fin_vld),
        .fin_idx(fin_idx),
        .ret_vld(ret_vld),
        .ret_u0 (ru0),
        .ret_u1 (ru1),
        .fin_err(fin_err)
    );

    assign disp_idx0 = tail_i;
    assign disp_idx1 = tail_i1;
    assign ret_unit0 = ru0;
    assign ret_unit1 = ru1;

endmodule

// File: rtl/cq_ctrl_chk.sv
module cq_ctrl_chk #(
    parameter  int DEPTH  = 6,
    parameter  bit BYPASS = 1'b0,
    localparam int IDXW   = $clog2(DEPTH)
) (
    input logic            clk,
    input logic            rst,
    input logic [1:0]      disp_req,
    input logic [1:0]      disp_grant,
    input logic [IDXW-1:0] disp_idx0,
    input logic [IDXW-1:0] disp_idx1,
    input logic            iq_hold,
    input logic [1:0]      ret_vld
);
    // Occupancy rebuilt from the port traffic alone.
    int occ_m;
    int ret_m;
    int free_m;

    assign ret_m  = int'(ret_vld[0]) + int'(ret_vld[1]);
    assign free_m = DEPTH - occ_m + (BYPASS ? ret_m : 0);

    always_ff @(posedge clk) begin
        if (rst) occ_m <= 0;
        else     occ_m <= occ_m + int'(disp_grant) - ret_m;
    end

    p_grant_fits_r3: assert property (@(posedge clk) disable iff (rst)
        int'(disp_grant) <= free_m);

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
        occ_m >= 0 && occ_m <= DEPTH);

    p_hold_cause_r3: assert property (@(posedge clk) disable iff (rst)
        (iq_hold && disp_req <= 2'd2) |-> (free_m < int'(disp_req)));

    p_lane_order_r6: assert property (@(posedge clk) disable iff (rst)
        ret_vld[1] |-> ret_vld[0]);

    p_pair_needs_two_r6: assert property (@(posedge clk) disable iff (rst)
        ret_vld[1] |-> occ_m >= 2);

    p_empty_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (occ_m == 0) |-> (ret_vld == 2'b00));

    p_full_stalls_r7: assert property (@(posedge clk) disable iff (rst)
        (!BYPASS && occ_m == DEPTH) |-> (disp_grant == 2'd0));

    p_idx_wrap_r10: assert property (@(posedge clk) disable iff (rst)
        (disp_grant == 2'd2) |->
        (int'(disp_idx1) == ((int'(disp_idx0) + 1) % DEPTH)));

endmodule

bind cq_ctrl cq_ctrl_chk #(.DEPTH(DEPTH), .BYPASS(BYPASS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .disp_req  (disp_req),
    .disp_grant(disp_grant),
    .disp_idx0 (disp_idx0),
    .disp_idx1 (disp_idx1),
    .iq_hold   (iq_hold),
    .ret_vld   (ret_vld)
);

// File: tb/cq_ctrl_test.sv
module cq_ctrl_test;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [1:0]      disp_req = '0, disp_unit0 = '0, disp_unit1 = '0;
    logic [1:0]      disp_grant;
    logic [2:0]      disp_idx0, disp_idx1;
    logic            iq_hold;
    logic [1:0]      fin_vld = '0;
    logic [1:0][2:0] fin_idx = '0;
    logic            fin_err;
    logic [1:0]      ret_vld, ret_unit0, ret_unit1;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    cq_ctrl uut (
        .clk(clk), .rst(rst),
        .disp_req(disp_req), .disp_unit0(disp_unit0), .disp_unit1(disp_unit1),
        .disp_grant(disp_grant), .disp_idx0(disp_idx0), .disp_idx1(disp_idx1),
        .iq_hold(iq_hold), .fin_vld(fin_vld), .fin_idx(fin_idx), .fin_err(fin_err),
        .ret_vld(ret_vld), .ret_unit0(ret_unit0), .ret_unit1(ret_unit1)
    );

    typedef struct packed {
        logic [1:0] req, u0, u1, fv;
        logic [2:0] fi0, fi1;
        logic [1:0] g;
        logic       h;
        logic [1:0] rv, ru0, ru1;
        logic       err;
        logic [2:0] ix;
    } vec_t;

    // Units: INT=0 FP=1 LSU=2 BR=3
    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{2'd2, 2'd0, 2'd1, 2'b00, 3'd0, 3'd0, 2'd2, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0}, // R2 R9
        '{2'd2, 2'd2, 2'd3, 2'b01, 3'd1, 3'd0, 2'd2, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd2}, // R5 younger done
        '{2'd2, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd2, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd4}, // R5 wait
        '{2'd1, 2'd1, 2'd0, 2'b11, 3'd0, 3'd3, 2'd0, 1'b1, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0}, // R3 full, R4
        '{2'd2, 2'd1, 2'd1, 2'b00, 3'd0, 3'd0, 2'd0, 1'b1, 2'b11, 2'd0, 2'd1, 1'b0, 3'd0}, // R7 R6 R9
        '{2'd2, 2'd1, 2'd2, 2'b00, 3'd0, 3'd0, 2'd2, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0}, // R10 wrap
        '{2'd0, 2'd0, 2'd0, 2'b01, 3'd2, 3'd0, 2'd0, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0},
        '{2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0, 1'b0, 2'b11, 2'd2, 2'd3, 1'b0, 3'd0}, // R4 R9
        '{2'd0, 2'd0, 2'd0, 2'b10, 3'd0, 3'd2, 2'd0, 1'b0, 2'b00, 2'd0, 2'd0, 1'b1, 3'd0}, // R8 empty
        '{2'd0, 2'd0, 2'd0, 2'b01, 3'd4, 3'd0, 2'd0, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0},
        '{2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0, 1'b0, 2'b01, 2'd0, 2'd0, 1'b0, 3'd0}, // R6 one lane
        '{2'd0, 2'd0, 2'd0, 2'b11, 3'd5, 3'd1, 2'd0, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0},
        '{2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0, 1'b0, 2'b01, 2'd0, 2'd0, 1'b0, 3'd0}, // R5
        '{2'd0, 2'd0, 2'd0, 2'b01, 3'd0, 3'd0, 2'd0, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd0},
        '{2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0, 2'd0, 1'b0, 2'b11, 2'd1, 2'd2, 1'b0, 3'd0}, // R9
        '{2'd2, 2'd0, 2'd3, 2'b00, 3'd0, 3'd0, 2'd2, 1'b0, 2'b00, 2'd0, 2'd0, 1'b0, 3'd2}  // R10
    };

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    task automatic drive(input logic [1:0] rq, input logic [1:0] a, input logic [1:0] b,
                         input logic [1:0] fv, input logic [2:0] f0, input logic [2:0] f1);
        @(negedge clk);
        disp_req = rq; disp_unit0 = a; disp_unit1 = b;
        fin_vld = fv; fin_idx[0] = f0; fin_idx[1] = f1;
        #1;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        drive(2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R1 ret_vld", ret_vld, 0);
        check("R1 hold", iq_hold, 0);
        check("R1 err", fin_err, 0);

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].req, TBL[i].u0, TBL[i].u1, TBL[i].fv, TBL[i].fi0, TBL[i].fi1);
            check($sformatf("R2 grant v%0d", i), disp_grant, TBL[i].g);
            check($sformatf("R3 hold v%0d", i), iq_hold, TBL[i].h);
            check($sformatf("R6 ret_vld v%0d", i), ret_vld, TBL[i].rv);
            check($sformatf("R8 err v%0d", i), fin_err, TBL[i].err);
            if (TBL[i].g != 0) check($sformatf("R10 idx0 v%0d", i), disp_idx0, TBL[i].ix);
            if (TBL[i].g == 2) check($sformatf("R10 idx1 v%0d", i), disp_idx1, (TBL[i].ix + 1) % 6);
            if (TBL[i].rv[0]) check($sformatf("R9 unit0 v%0d", i), ret_unit0, TBL[i].ru0);
            if (TBL[i].rv[1]) check($sformatf("R9 unit1 v%0d", i), ret_unit1, TBL[i].ru1);
        end

        // R8: out-of-range index, and empty slot 0
        drive(2'd0, 2'd0, 2'd0, 2'b01, 3'd7, 3'd0);
        check("R8 range err", fin_err, 1);
        drive(2'd0, 2'd0, 2'd0, 2'b10, 3'd0, 3'd0);
        check("R8 empty err", fin_err, 1);
        drive(2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R8 no effect", ret_vld, 0);

        // R1: finished flags cleared by reset
        drive(2'd0, 2'd0, 2'd0, 2'b11, 3'd2, 3'd3);
        check("R4 mark ok", fin_err, 0);
        @(negedge clk); rst = 1'b1; fin_vld = '0;
        @(negedge clk); rst = 1'b0;
        drive(2'd1, 2'd3, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R1 no retire after reset", ret_vld, 0);
        check("R1 grant", disp_grant, 1);
        check("R1 idx0", disp_idx0, 0);
        check("R2 single no hold", iq_hold, 0);
        drive(2'd2, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R1 still no retire", ret_vld, 0);
        check("R2 idx0 next", disp_idx0, 1);
        drive(2'd2, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R2 idx0 third", disp_idx0, 3);
        drive(2'd2, 2'd1, 2'd1, 2'b00, 3'd0, 3'd0);
        check("R2 partial grant", disp_grant, 1);
        check("R3 partial hold", iq_hold, 1);
        check("R10 last slot", disp_idx0, 5);
        drive(2'd1, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);
        check("R3 full grant", disp_grant, 0);
        check("R3 full hold", iq_hold, 1);
        drive(2'd0, 2'd0, 2'd0, 2'b00, 3'd0, 3'd0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule